// File: doc/BRIEF.md
# Printable-Byte Payload Sorter

This block sits behind a header walker in a packet-monitoring datapath. Each packet arrives as a stream of multi-byte beats. On the first beat, the walker also presents the byte offset at which the payload starts and the payload length. The sorter checks every byte inside that window for being readable text. While it does so it keeps two measures: the current run of consecutive text bytes, which carries from one beat to the next, and the total number of text bytes seen so far.

A packet counts as plain text, and should be kept, as soon as either of two things happens. The first is that some run of text bytes reaches a burst threshold. The second is that the text bytes reach a given percentage of the payload length. If neither happens by the last beat, the packet counts as encrypted and should be discarded. The sorter emits exactly one verdict per packet, in packet order. When a threshold is met part-way through a packet, the verdict is emitted right away and the rest of that packet is still consumed. Both thresholds are run-time inputs.

Top module: `printable_payload_sorter`

## Requirements
- R1: A payload byte counts as text exactly when its value is in 0x20..0x7E; 0x1F and 0x7F are not text.
- R2: A packet whose payload contains at least `burst_thr` consecutive text bytes gets a plain verdict (`v_plain`=1); a longest run of `burst_thr`-1 is not enough on its own.
- R3: A packet gets a plain verdict when text_count×100 ≥ `pct_thr`×payload_length, where the equality case counts as plain. This is checked after every beat.
- R4: A packet meeting neither R2 nor R3 by its last beat gets `v_valid`=1 with `v_plain`=0 one cycle after the beat that has `s_last`=1.
- R5: The verdict is raised one cycle after the first beat at which R2 or R3 holds, even when that beat is not the last one.
- R6: Exactly one verdict pulse is produced per packet, in packet order; no verdict is produced in a cycle that follows a cycle without `s_valid`.
- R7: Bytes before `pay_off`, bytes at or past `pay_off`+`pay_len`, and bytes whose `s_keep` bit is 0 neither count as text nor break a run.
- R8: The run count carries across beat boundaries and returns to zero on any non-text payload byte.
- R9: A packet with `pay_len`=0 gets a plain verdict of 0 (encrypted), whatever the thresholds are.
- R10: During and right after reset, `v_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Beat present this cycle |
| s_data | input | BYTES×8 | Beat bytes; byte k is in bits 8k+7..8k and sits at packet position beat×BYTES+k |
| s_keep | input | BYTES | Per-byte enable |
| s_last | input | 1 | Final beat of the packet |
| pay_off | input | LEN_W | Payload start offset in bytes, sampled on the first beat |
| pay_len | input | LEN_W | Payload length in bytes, sampled on the first beat |
| burst_thr | input | LEN_W | Run length that makes a packet plain |
| pct_thr | input | 7 | Text share that makes a packet plain, in percent |
| v_valid | output | 1 | One-cycle verdict pulse |
| v_plain | output | 1 | 1 = plain text, forward; 0 = encrypted, drop |

## Verification
The bench aims at the threshold edges: a run one byte short of the burst limit, and a text share exactly at the percentage and one point above it. A design that used a strict comparison, or kept an off-by-one run count, would flip these verdicts. Alternating and edge-value patterns using 0x1F, 0x20, 0x7E and 0x7F would catch a wrong text range. Printable header and trailer bytes around a binary payload would catch a design that ignored the window. A run that starts in one beat and ends in another would expose a counter that clears at beat boundaries. Packets that are decided early are followed at once by their successors, so a second verdict from the tail of the first packet, or a missing one, shows up as a stray or absent pulse. A zero-length payload would catch a share test that treats 0 ≥ 0 as plain.

// File: rtl/pps_pkg.sv
package pps_pkg;

  localparam int PCT_W = 7;

  // readable text range
  function automatic logic is_text(input logic [7:0] b);
    return (b >= 8'd32) && (b <= 8'd126);
  endfunction

  // share test without division; an empty payload never qualifies
  function automatic logic share_met(input logic [31:0] cnt,
                                     input logic [31:0] len,
                                     input logic [PCT_W-1:0] pct);
    logic [39:0] lhs;
    logic [39:0] rhs;
    lhs = 40'(cnt) * 40'd100;
    rhs = 40'(pct) * 40'(len);
    return (len != 32'd0) && (lhs >= rhs);
  endfunction

endpackage

// File: rtl/pps_lane.sv
module pps_lane #(
  parameter int LEN_W = 16
) (
  input  logic [7:0]       byte_i,
  input  logic             in_pay_i,
  input  logic [LEN_W-1:0] run_i,
  input  logic [LEN_W-1:0] burst_thr_i,
  output logic [LEN_W-1:0] run_o,
  output logic             text_o,
  output logic             hit_o
);
  import pps_pkg::*;

  logic             txt;
  logic [LEN_W-1:0] inc;

  assign txt    = is_text(byte_i);
  assign inc    = run_i + LEN_W'(1);
  assign text_o = in_pay_i && txt;
  assign run_o  = !in_pay_i ? run_i : (txt ? inc : '0);
  assign hit_o  = text_o && (inc >= burst_thr_i);
endmodule

// File: rtl/pps_beat_scan.sv
module pps_beat_scan #(
  parameter int BYTES = 8,
  parameter int LEN_W = 16,
  localparam int CW   = $clog2(BYTES + 1)
) (
  input  logic [BYTES*8-1:0] data_i,
  input  logic [BYTES-1:0]   keep_i,
  input  logic [31:0]        base_i,
  input  logic [31:0]        pay_lo_i,
  input  logic [31:0]        pay_hi_i,
  input  logic [LEN_W-1:0]   run_i,
  input  logic [LEN_W-1:0]   burst_thr_i,
  output logic [LEN_W-1:0]   run_o,
  output logic [CW-1:0]      count_o,
  output logic               burst_hit_o
);
  logic [LEN_W-1:0] run_c [BYTES+1];
  logic [BYTES-1:0] text_v;
  logic [BYTES-1:0] hit_v;

  assign run_c[0] = run_i;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [31:0] pos;
    logic        in_pay;
    assign pos    = base_i + 32'(g);
    assign in_pay = keep_i[g] && (pos >= pay_lo_i) && (pos < pay_hi_i);
    pps_lane #(.LEN_W(LEN_W)) u_lane (
      .byte_i      (data_i[g*8 +: 8]),
      .in_pay_i    (in_pay),
      .run_i       (run_c[g]),
      .burst_thr_i (burst_thr_i),
      .run_o       (run_c[g+1]),
      .text_o      (text_v[g]),
      .hit_o       (hit_v[g])
    );
  end

  always_comb begin
    count_o = '0;
    for (int i = 0; i < BYTES; i++) count_o = count_o + CW'(text_v[i]);
  end

  assign run_o       = run_c[BYTES];
  assign burst_hit_o = |hit_v;
endmodule

// File: rtl/printable_payload_sorter.sv
module printable_payload_sorter #(
  parameter int BYTES = 8,
  parameter int LEN_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s_valid,
  input  logic [BYTES*8-1:0] s_data,
  input  logic [BYTES-1:0]   s_keep,
  input  logic               s_last,
  input  logic [LEN_W-1:0]   pay_off,
  input  logic [LEN_W-1:0]   pay_len,
  input  logic [LEN_W-1:0]   burst_thr,
  input  logic [6:0]         pct_thr,
  output logic               v_valid,
  output logic               v_plain
);
  import pps_pkg::*;

  localparam int CW = $clog2(BYTES + 1);

  logic             mid_q, done_q;
  logic [LEN_W-1:0] beat_q, off_q, len_q, run_q, cnt_q;

  // per-beat view, first beat takes the live header fields
  logic             sop;
  logic [LEN_W-1:0] off_cur, len_cur, bidx, run_in, cnt_in, run_out, cnt_next;
  logic             done_in;
  logic [31:0]      base, pay_lo, pay_hi;
  logic [CW-1:0]    beat_cnt;
  logic             burst_hit, share_hit, plain_now, fire_early, fire_end;

  assign sop     = !mid_q;
  assign off_cur = sop ? pay_off : off_q;
  assign len_cur = sop ? pay_len : len_q;
  assign bidx    = sop ? '0 : beat_q;
  assign run_in  = sop ? '0 : run_q;
  assign cnt_in  = sop ? '0 : cnt_q;
  assign done_in = sop ? 1'b0 : done_q;

  assign base   = 32'(bidx) * 32'(BYTES);
  assign pay_lo = 32'(off_cur);
  assign pay_hi = pay_lo + 32'(len_cur);

  pps_beat_scan #(.BYTES(BYTES), .LEN_W(LEN_W)) u_scan (
    .data_i      (s_data),
    .keep_i      (s_keep),
    .base_i      (base),
    .pay_lo_i    (pay_lo),
    .pay_hi_i    (pay_hi),
    .run_i       (run_in),
    .burst_thr_i (burst_thr),
    .run_o       (run_out),
    .count_o     (beat_cnt),
    .burst_hit_o (burst_hit)
  );

  assign cnt_next   = cnt_in + LEN_W'(beat_cnt);
  assign share_hit  = share_met(32'(cnt_next), 32'(len_cur), pct_thr);
  assign plain_now  = burst_hit || share_hit;
  assign fire_early = s_valid && !done_in && plain_now;
  assign fire_end   = s_valid && s_last && !done_in && !plain_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q   <= 1'b0;
      done_q  <= 1'b0;
      beat_q  <= '0;
      off_q   <= '0;
      len_q   <= '0;
      run_q   <= '0;
      cnt_q   <= '0;
      v_valid <= 1'b0;
      v_plain <= 1'b0;
    end else begin
      v_valid <= fire_early || fire_end;
      v_plain <= fire_early;
      if (s_valid) begin
        mid_q  <= !s_last;
        done_q <= done_in || fire_early;
        beat_q <= bidx + LEN_W'(1);
        off_q  <= off_cur;
        len_q  <= len_cur;
        run_q  <= run_out;
        cnt_q  <= cnt_next;
      end
    end
  end
endmodule

// File: rtl/pps_checks.sv
module pps_checks #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_last,
  input logic             v_valid,
  input logic             v_plain,
  input logic [LEN_W-1:0] len_cur,
  input logic             plain_now
);
  logic last_d, seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_d <= 1'b0;
      seen   <= 1'b0;
    end else begin
      last_d <= s_valid && s_last;
      if (last_d)       seen <= 1'b0;
      else if (v_valid) seen <= 1'b1;
    end
  end

  p_no_idle_verdict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    v_valid |-> $past(s_valid));

  p_single_verdict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    v_valid |-> !seen);

  p_verdict_by_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last_d |-> (v_valid || seen));

  p_empty_encrypted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (v_valid && $past(len_cur == '0)) |-> !v_plain);

  // plain needs a run hit (R2) or a share hit (R3) on the prior beat
  p_plain_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (v_valid && v_plain) |-> $past(plain_now));

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |=> !v_valid);
endmodule

bind printable_payload_sorter pps_checks #(.LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_valid   (s_valid),
  .s_last    (s_last),
  .v_valid   (v_valid),
  .v_plain   (v_plain),
  .len_cur   (len_cur),
  .plain_now (plain_now)
);

// File: tb/sim_printable_payload_sorter.sv
module sim_printable_payload_sorter;
  localparam int BYTES = 8;
  localparam int LEN_W = 16;

  typedef struct packed {
    int kind; int p; int off; int len; int tail; int burst; int pct; bit plain;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{0, 0, 14,  20, 3, 12,  50, 1'b1},  // R5 early by share
    '{1, 0, 14,  30, 2, 12,  50, 1'b0},  // R4, R7 text header/tail
    '{2, 0,  0,  40, 0, 12,  50, 1'b1},  // R3 exact share
    '{2, 0,  0,  40, 0, 12,  51, 1'b0},  // R3 one point above
    '{3, 11, 6, 100, 0, 12,  50, 1'b0},  // R2 run one short
    '{3, 12, 6, 100, 0, 12,  50, 1'b1},  // R2, R8 run across beats
    '{4, 0,  3,  60, 5,  6,  90, 1'b0},  // R1 0x7F breaks run
    '{5, 0,  3,  60, 5,  6,  90, 1'b0},  // R1 0x1F breaks run
    '{4, 0,  3,  60, 5,  5,  90, 1'b1},  // R1 0x20 is text
    '{0, 0, 10,   0, 8, 12,  50, 1'b0},  // R9 empty payload
    '{3, 12, 0,  12, 30, 12, 100, 1'b1}, // R5, R7 early with text tail
    '{1, 0,  0,  16, 0, 12,   0, 1'b1}   // R3 zero percent
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               s_valid = 1'b0;
  logic [BYTES*8-1:0] s_data = '0;
  logic [BYTES-1:0]   s_keep = '0;
  logic               s_last = 1'b0;
  logic [LEN_W-1:0]   pay_off = '0, pay_len = '0, burst_thr = '0;
  logic [6:0]         pct_thr = '0;
  logic               v_valid, v_plain;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  printable_payload_sorter #(.BYTES(BYTES), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_keep(s_keep),
    .s_last(s_last), .pay_off(pay_off), .pay_len(pay_len), .burst_thr(burst_thr),
    .pct_thr(pct_thr), .v_valid(v_valid), .v_plain(v_plain)
  );

  function automatic logic [7:0] gen(int kind, int p, int i);
    case (kind)
      0: return 8'h41;
      1: return 8'h80;
      2: return (i % 2 == 0) ? 8'h61 : 8'h00;
      3: return (i < p) ? 8'h7E : 8'hFF;
      4: return (i % 6 == 5) ? 8'h7F : 8'h20;
      5: return (i % 6 == 5) ? 8'h1F : 8'h41;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] pkt_byte(vec_t v, int pos);
    if (pos < v.off || pos >= v.off + v.len) return 8'h48;
    return gen(v.kind, v.p, pos - v.off);
  endfunction

  // reference: beat index of the verdict and its value
  function automatic int model(vec_t v, output bit plain);
    int total, nb, run, cnt;
    bit hit;
    total = v.off + v.len + v.tail;
    nb = (total + BYTES - 1) / BYTES;
    run = 0; cnt = 0; hit = 0;
    for (int b = 0; b < nb; b++) begin
      for (int k = 0; k < BYTES; k++) begin
        int pos;
        logic [7:0] c;
        pos = b * BYTES + k;
        if (pos >= v.off && pos < v.off + v.len && pos < total) begin
          c = pkt_byte(v, pos);
          if (c >= 8'h20 && c < 8'h7F) begin
            run++; cnt++;
            if (run >= v.burst) hit = 1;
          end else run = 0;
        end
      end
      if (v.len != 0 && (hit || cnt * 100 >= v.pct * v.len)) begin
        plain = 1;
        return b;
      end
    end
    plain = 0;
    return nb - 1;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(int idx);
    vec_t v;
    int total, nb, eb, stray, got;
    bit ep;
    v = VEC[idx];
    total = v.off + v.len + v.tail;
    nb = (total + BYTES - 1) / BYTES;
    eb = model(v, ep);
    stray = 0;
    got = -1;
    for (int b = 0; b < nb; b++) begin
      s_valid   = 1'b1;
      s_last    = (b == nb - 1);
      pay_off   = LEN_W'(v.off);
      pay_len   = LEN_W'(v.len);
      burst_thr = LEN_W'(v.burst);
      pct_thr   = 7'(v.pct);
      for (int k = 0; k < BYTES; k++) begin
        int pos;
        pos = b * BYTES + k;
        s_keep[k] = (pos < total);
        s_data[k*8 +: 8] = (pos < total) ? pkt_byte(v, pos) : 8'h41;
      end
      @(negedge clk);
      if (v_valid) begin
        if (b == eb && got < 0) got = int'(v_plain);
        else stray++;
      end
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
    // R2 R3 R4 R5 R9: verdict value and its beat
    check(got == int'(ep) && ep == v.plain, "R2/R3/R4/R5/R9",
          $sformatf("vector %0d verdict at beat %0d", idx, eb), got, int'(v.plain));
    // R6: no extra or misplaced pulse
    check(stray == 0, "R6", $sformatf("vector %0d stray verdicts", idx), stray, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(v_valid == 1'b0, "R10", "v_valid in reset", int'(v_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(v_valid == 1'b0, "R10", "v_valid after reset", int'(v_valid), 0);
    for (int i = 0; i < NV; i++) run_vec(i);
    @(negedge clk);
    check(v_valid == 1'b0, "R6", "v_valid when idle", int'(v_valid), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule